// File: doc/BRIEF.md
# Banked Interrupt Mask Controller

This block collects level-sensitive interrupt sources and raises one request line to the processor. The sources are grouped into banks of 32. Each bank has its own registers on a simple register bus. Every source input first passes through a two-stage synchroniser. A per-source mask bit then decides whether that source may take part in the request.

Software never writes the mask register directly. It sets mask bits through a write-one-to-set strobe register and clears them through a write-one-to-clear strobe register. Two masters can therefore change different sources without a read-modify-write race. The same two strobes form the sleep path. Before sleep, software reads the mask and keeps that snapshot, then writes the inverse of the wake set to the set strobe. On wake-up it writes the inverse of the snapshot to the clear strobe, which brings the mask back to its earlier value.

Top module: `irqc_top`

## Requirements
- R1: After reset every source is masked: each bank's mask register reads all ones, and the request output is low.
- R2: Bank n occupies the byte window starting at n*0x20. Source i belongs to bank i/32, at bit i%32. Within a bank the word offsets are:
  - 0x00: synchronised raw status
  - 0x04: mask
  - 0x08: mask-set
  - 0x0C: mask-clear
  - 0x10: pending
- R3: Writing the mask-set offset sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Writing the mask-clear offset clears each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R5: Reading the pending offset returns the synchronised raw status AND NOT the mask.
- R6: The request output is the OR of all pending bits across all banks, registered once. A source change reaches the output on the third rising edge after it is applied. A mask write changes the output on the edge after the write edge.
- R7: The mask-set and mask-clear offsets read as zero. Writes to the raw status and pending offsets leave the mask unchanged.
- R8: Sources are level-sensitive. A pending bit clears when its source deasserts, and no acknowledge write is needed.
- R9: After software writes the inverse of a wake set to mask-set, only sources in the wake set can raise the request. Writing the inverse of a saved mask to mask-clear restores a saved mask of zero.
- R10: Read data appears on the clock edge that samples the read and holds until the next read. Offsets 0x14 to 0x1C, and banks beyond the last one, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt sources, asynchronous |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
A corrupted mask bit shows up in two places. Reading the mask offset exposes it on the next read. It also changes the request output one edge after the bad update, because the mask feeds the pending OR directly. A decode fault, where a strobe lands in the wrong bank or a status write is taken as a mask write, shows up as an unexpected mask readback on the next read. A synchroniser with the wrong depth moves the request edge away from the third clock after a source change, which the bench times exactly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // Word offset of a register inside one bank window; the order is the address map.
    typedef enum logic [2:0] {
        OFF_RAW  = 3'd0,
        OFF_MASK = 3'd1,
        OFF_SET  = 3'd2,
        OFF_CLR  = 3'd3,
        OFF_PEND = 3'd4
    } reg_off_e;

    localparam int BANK_STRIDE_LSB = 5;   // 0x20-byte window per bank
    localparam int WORD_LSB        = 2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            state_d.chain[s] = state_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_o = state_q.chain[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       off_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] mask_o,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] rd_data_o
);
    typedef struct packed {
        logic [WIDTH-1:0] mask;
    } bank_state_t;

    bank_state_t state_d, state_q;
    logic [WIDTH-1:0] pend;

    always_comb begin
        state_d = state_q;
        pend    = raw_i & ~state_q.mask;
        if (wr_en_i) begin
            case (off_i)
                OFF_SET: state_d.mask = state_q.mask | wdata_i;
                OFF_CLR: state_d.mask = state_q.mask & ~wdata_i;
                default: state_d.mask = state_q.mask;
            endcase
        end
        case (off_i)
            OFF_RAW:  rd_data_o = raw_i;
            OFF_MASK: rd_data_o = state_q.mask;
            OFF_PEND: rd_data_o = pend;
            default:  rd_data_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{mask: '1};
        else        state_q <= state_d;
    end

    assign mask_o = state_q.mask;
    assign pend_o = pend;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_BANKS*32-1:0] src_i,
    input  logic                    bus_sel_i,
    input  logic                    bus_wr_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [31:0]             bus_wdata_i,
    output logic [31:0]             bus_rdata_o,
    output logic                    irq_o
);
    localparam int BANK_W     = 32;
    localparam int NUM_SRC    = NUM_BANKS * BANK_W;
    localparam int BANK_IDX_W = ADDR_W - BANK_STRIDE_LSB;

    typedef struct packed {
        logic [BANK_W-1:0] rdata;
        logic              irq;
    } top_state_t;

    top_state_t state_d, state_q;

    logic [NUM_SRC-1:0]              raw_sync;
    logic [NUM_SRC-1:0]              mask_all;
    logic [NUM_SRC-1:0]              pend_all;
    logic [NUM_BANKS-1:0][BANK_W-1:0] rd_bank;
    logic [BANK_IDX_W-1:0]           bank_idx;
    logic [2:0]                      reg_off;

    assign bank_idx = bus_addr_i[ADDR_W-1:BANK_STRIDE_LSB];
    assign reg_off  = bus_addr_i[BANK_STRIDE_LSB-1:WORD_LSB];

    irqc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (raw_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_sel_i && bus_wr_i && (bank_idx == BANK_IDX_W'(b));

        irqc_bank #(.WIDTH(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (bank_wr),
            .off_i     (reg_off),
            .wdata_i   (bus_wdata_i),
            .raw_i     (raw_sync[b*BANK_W +: BANK_W]),
            .mask_o    (mask_all[b*BANK_W +: BANK_W]),
            .pend_o    (pend_all[b*BANK_W +: BANK_W]),
            .rd_data_o (rd_bank[b])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.irq = |pend_all;
        if (bus_sel_i && !bus_wr_i) begin
            state_d.rdata = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == BANK_IDX_W'(b)) state_d.rdata = rd_bank[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata_o = state_q.rdata;
    assign irq_o       = state_q.irq;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NUM_SRC-1:0] mask_all,
    input logic [NUM_SRC-1:0] pend_all,
    input logic               irq
);
    logic wr_set0, wr_clr0, wr_ro0;
    assign wr_set0 = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
    assign wr_clr0 = bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
    assign wr_ro0  = bus_sel && bus_wr && ((bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(0)) ||
                                           (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4)));

    // R1: the first cycle out of reset has no request
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !irq);

    // R6: request is the registered OR of the pending vector
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|pend_all));

    // R3: set strobe turns on the written ones and keeps the rest
    assert_set_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set0 |=> ((mask_all[31:0] & $past(bus_wdata)) == $past(bus_wdata)) &&
                    ((mask_all[31:0] & ~$past(bus_wdata)) == ($past(mask_all[31:0]) & ~$past(bus_wdata))));

    // R4: clear strobe turns off the written ones and keeps the rest
    assert_clr_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr0 |=> ((mask_all[31:0] & $past(bus_wdata)) == 32'd0) &&
                    ((mask_all[31:0] & ~$past(bus_wdata)) == ($past(mask_all[31:0]) & ~$past(bus_wdata))));

    // R7: writes to the status and pending offsets do not touch the mask
    assert_ro_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ro0 |=> $stable(mask_all));
endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel_i),
    .bus_wr    (bus_wr_i),
    .bus_addr  (bus_addr_i),
    .bus_wdata (bus_wdata_i),
    .mask_all  (mask_all),
    .pend_all  (pend_all),
    .irq       (irq_o)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irqc_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_sel_i   (bus_sel),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: issue a read and queue what it must return
    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic irq_check(input logic exp, input string req);
        @(negedge clk);
        check(req, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // monitor: compare read data just after the edge that sampled the read
    initial begin
        forever begin
            bit rd_now;
            @(posedge clk);
            rd_now = bus_sel && !bus_wr;
            #1;
            if (rd_now && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        irq_check(1'b0, "R1 irq after reset");
        bus_read(8'h04, 32'hFFFF_FFFF, "R1 mask bank0 reset");
        bus_read(8'h24, 32'hFFFF_FFFF, "R1 mask bank1 reset");

        // R2/R5 raw and pending with all masked
        src = 64'h1234_5678_0000_00F5;
        settle();
        bus_read(8'h00, 32'h0000_00F5, "R2 raw bank0");
        bus_read(8'h20, 32'h1234_5678, "R2 raw bank1");
        bus_read(8'h10, 32'h0000_0000, "R5 pending while masked");
        irq_check(1'b0, "R1 masked sources no irq");

        // R4 clear strobe
        bus_write(8'h0C, 32'h0000_00F0);
        bus_read(8'h04, 32'hFFFF_FF0F, "R4 clear strobe");
        bus_read(8'h10, 32'h0000_00F0, "R5 pending after unmask");
        irq_check(1'b1, "R6 irq from bank0");

        // R3 set strobe
        bus_write(8'h08, 32'h0000_0030);
        bus_read(8'h04, 32'hFFFF_FF3F, "R3 set strobe");
        bus_read(8'h10, 32'h0000_00C0, "R5 pending after set");

        // R7 strobes read zero, writes to status/pending ignored
        bus_read(8'h08, 32'h0, "R7 set reads zero");
        bus_read(8'h0C, 32'h0, "R7 clear reads zero");
        bus_write(8'h00, 32'h0000_0000);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'h0000_0000);
        bus_read(8'h04, 32'hFFFF_FF3F, "R7 mask unchanged after status/pending writes");
        bus_read(8'h24, 32'hFFFF_FFFF, "R7 bank1 mask unchanged");

        // mask everything again; mask write reaches irq on the next edge (R6)
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R6 irq one edge after mask write", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check("R6 irq drops after mask write", {31'd0, irq}, 32'd0);

        // R2 source 40 lives in bank1 bit 8
        src = 64'h0;
        settle();
        bus_write(8'h2C, 32'h0000_0100);
        @(negedge clk);
        src[40] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R6 irq not yet after two edges", {31'd0, irq}, 32'd0);
        @(posedge clk); #1;
        check("R6 irq on third edge", {31'd0, irq}, 32'd1);
        bus_read(8'h30, 32'h0000_0100, "R2 source 40 pending in bank1 bit8");
        bus_read(8'h10, 32'h0000_0000, "R2 bank0 pending stays clear");

        // R8 level: deassert without acknowledge
        src[40] = 1'b0;
        settle();
        irq_check(1'b0, "R8 irq clears with source");
        bus_read(8'h30, 32'h0, "R8 pending clears with source");

        // R9 sleep sequence
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0, "R9 saved mask bank0");
        bus_read(8'h24, 32'h0, "R9 saved mask bank1");
        bus_write(8'h08, ~32'h0000_0020);
        bus_write(8'h28, ~32'h0000_0020);
        bus_read(8'h04, 32'hFFFF_FFDF, "R9 sleep mask bank0");
        src = ~64'h0000_0020_0000_0020;
        settle();
        irq_check(1'b0, "R9 non-wake sources blocked");
        src[37] = 1'b1;
        settle();
        irq_check(1'b1, "R9 wake source 37 raises irq");
        bus_read(8'h30, 32'h0000_0020, "R9 only wake bit pending");
        bus_write(8'h0C, ~32'h0);
        bus_write(8'h2C, ~32'h0);
        bus_read(8'h04, 32'h0, "R9 restored mask bank0");
        bus_read(8'h24, 32'h0, "R9 restored mask bank1");
        bus_read(8'h10, ~32'h0000_0020, "R9 restored pending bank0");

        // R10 unmapped offsets and banks, and hold between reads
        bus_read(8'h14, 32'h0, "R10 unused offset");
        bus_read(8'h44, 32'h0, "R10 bank beyond last");
        bus_read(8'h00, ~32'h0000_0020, "R10 raw read");
        repeat (3) @(negedge clk);
        check("R10 read data held", bus_rdata, ~32'h0000_0020);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule